// File: doc/BRIEF.md
# Level-Sensitive Banked Interrupt Controller

This block gathers up to three banks of 32 level-sensitive interrupt lines and presents them to a processor as two request outputs: a normal class and a fast class. Each line carries a small level register that holds a 6-bit priority (smaller value is more urgent) and a bit that routes the line to the fast class. Software masks lines per bank through a plain mask register or through atomic set and clear registers. It can also raise lines by writing software-set bits, and it reads per-class views of what is pending and not masked.

Each class has an arm flag. While the flag is set and an unmasked pending line of that class exists, the controller picks a winner, latches its line number into the class's source-code register, raises the class output and clears the flag. The output and the code then hold until software rearms the class through the control register. A global mask bit in the control register keeps both outputs quiet. A write to the configuration register returns the whole block to its reset state. All register access is through a simple single-cycle 32-bit word port, and reads have no side effects.

Top module: `intc_level_banked`

## Requirements
- R1: After reset every mask bit reads 1. Pending, software and level registers read 0. Both source codes read 0. Both outputs are low and both classes are armed.
- R2: Bank b (b < NBANKS) has its registers at 0x80 + 0x20·b. A write to +0x04 loads the mask. A write to +0x08 clears the mask bits written as 1. A write to +0x0C sets the mask bits written as 1. +0x04 reads the mask, and +0x08 and +0x0C read 0.
- R3: Bank offset +0x00 reads the live inputs. A line whose input is high is pending from the next cycle on. When an input goes from high to low, its pending bit takes the value of its software bit.
- R4: A write to bank offset +0x10 ORs the value into both the software bits and the pending bits. A write to +0x14 clears the software bits written as 1 and loads pending with the remaining software bits ANDed with the inputs. Lines whose input is high stay pending.
- R5: Bank offset +0x18 reads pending & ~mask & ~route, and +0x1C reads pending & ~mask & route.
- R6: The level register of line n is at 0x100 + 4·n for n < 32·NBANKS. Bits [7:2] hold the priority and bit 0 routes the line to the fast class. Bit 1 and all higher bits read 0.
- R7: Among the unmasked pending lines of a class, the smallest priority value wins. On equal priority the higher line number wins. The normal code reads at 0x40 and the fast code at 0x44.
- R8: If a class is armed, has a candidate and the global mask is 0, its output goes high one cycle later and the winner is latched as its code. The class is then disarmed, and the output and the code hold until the class is rearmed.
- R9: Control register 0x48: writing bit 0 rearms the normal class and writing bit 1 rearms the fast class. The rearmed output is low in the next cycle, and arbitration may raise it again one cycle after that.
- R10: Control bit 2 is the global mask and reads back at bit 2. While it is 1 both outputs are low and no class fires.
- R11: Writing 1 to bit 1 of 0x10 returns all state to its reset value in the next cycle. 0x14 always reads 1.
- R12: 0x50 stores 2 bits that read back. 0x00 reads the REVISION parameter. Writes to 0x00, 0x14, 0x40, 0x44, the raw inputs and the pending views change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| line_i | input | 32·NBANKS | Level interrupt inputs, line n at bit n |
| bus_we | input | 1 | Write strobe for the word at bus_addr |
| bus_addr | input | 12 | Byte address inside the 4 KB window; bits [1:0] must be 0 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_norm_o | output | 1 | Normal-class request |
| irq_fast_o | output | 1 | Fast-class request |

## Verification
Arbitration is exercised with a single unmasked line, with two lines in different banks at different priorities, and with two lines of equal priority. Together these separate a priority comparison from a bare index order and confirm the direction of the tie break. Pending is tested with inputs that rise and fall while software bits are present and absent. This tells the level rule apart from a latched one and exposes the way a software-clear write drops other software-only bits. Rearming under the global mask, a soft reset and writes to read-only addresses show that the outputs and stored state respond only through the intended registers.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int PRIO_W = 6;

  // Per-bank register selector, address bits [4:2] inside a bank window
  typedef enum logic [2:0] {
    BR_RAW  = 3'd0,
    BR_MASK = 3'd1,
    BR_MCLR = 3'd2,
    BR_MSET = 3'd3,
    BR_SSET = 3'd4,
    BR_SCLR = 3'd5,
    BR_PNRM = 3'd6,
    BR_PFST = 3'd7
  } bank_reg_e;

  localparam logic [11:0] A_REV   = 12'h000;
  localparam logic [11:0] A_CFG   = 12'h010;
  localparam logic [11:0] A_STAT  = 12'h014;
  localparam logic [11:0] A_CODEN = 12'h040;
  localparam logic [11:0] A_CODEF = 12'h044;
  localparam logic [11:0] A_CTRL  = 12'h048;
  localparam logic [11:0] A_IDLE  = 12'h050;
endpackage

// File: rtl/intc_bank.sv
module intc_bank
  import intc_pkg::*;
#(
  parameter int LINES = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         soft_rst,
  input  logic [LINES-1:0]             line_i,
  input  logic                         reg_we,
  input  bank_reg_e                    reg_sel,
  input  logic [LINES-1:0]             wdata,
  input  logic                         ilr_we,
  input  logic [$clog2(LINES)-1:0]     ilr_idx,
  input  logic [PRIO_W+1:0]            ilr_wdata,
  output logic [LINES-1:0]             pend_o,
  output logic [LINES-1:0]             mask_o,
  output logic [LINES-1:0]             route_o,
  output logic [LINES-1:0][PRIO_W-1:0] prio_o
);
  logic [LINES-1:0] pend_q, pend_n, swi_q, swi_n, mask_q, mask_n, inq_q, fall;
  logic [LINES-1:0] route_q, route_n;
  logic [LINES-1:0][PRIO_W-1:0] prio_q, prio_n;
  logic lvl_en;

  assign fall = inq_q & ~line_i;

  always_comb begin
    swi_n  = swi_q;
    mask_n = mask_q;
    pend_n = (pend_q & ~fall) | (swi_q & fall);
    if (reg_we) begin
      case (reg_sel)
        BR_MASK: mask_n = wdata;
        BR_MCLR: mask_n = mask_q & ~wdata;
        BR_MSET: mask_n = mask_q | wdata;
        BR_SSET: begin
          swi_n  = swi_q | wdata;
          pend_n = pend_n | wdata;
        end
        BR_SCLR: begin
          swi_n  = swi_q & ~wdata;
          pend_n = swi_n & line_i;
        end
        default: ;
      endcase
    end
    pend_n = pend_n | line_i;
    if (soft_rst) begin
      swi_n  = '0;
      mask_n = '1;
      pend_n = '0;
    end
  end

  always_comb begin
    prio_n  = prio_q;
    route_n = route_q;
    if (ilr_we) begin
      prio_n[ilr_idx]  = ilr_wdata[PRIO_W+1:2];
      route_n[ilr_idx] = ilr_wdata[0];
    end
    if (soft_rst) begin
      prio_n  = '0;
      route_n = '0;
    end
  end

  assign lvl_en = ilr_we | soft_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      swi_q   <= '0;
      mask_q  <= '1;
      inq_q   <= '0;
      prio_q  <= '0;
      route_q <= '0;
    end else begin
      pend_q <= pend_n;
      swi_q  <= swi_n;
      mask_q <= mask_n;
      inq_q  <= soft_rst ? '0 : line_i;
      if (lvl_en) begin
        prio_q  <= prio_n;
        route_q <= route_n;
      end
    end
  end

  assign pend_o  = pend_q;
  assign mask_o  = mask_q;
  assign route_o = route_q;
  assign prio_o  = prio_q;

  // R3: every input seen high is pending one cycle later
  a_r3_pend_covers_line: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst |=> ((pend_q & $past(line_i)) == $past(line_i)));
  // R2: bits written to mask-set are masked afterwards
  a_r2_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == BR_MSET && !soft_rst) |=> ((mask_q & $past(wdata)) == $past(wdata)));
  // R11: soft reset restores mask and software bits
  a_r11_soft_clears: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (mask_q == '1 && swi_q == '0 && route_q == '0));
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
#(
  parameter int NLINES = 96,
  parameter int IDX_W  = $clog2(NLINES)
) (
  input  logic [NLINES-1:0]             cand,
  input  logic [NLINES-1:0][PRIO_W-1:0] prio,
  output logic                          found,
  output logic [IDX_W-1:0]              idx
);
  logic [PRIO_W-1:0] best;

  // Scan upwards; "<=" lets a later line take over on equal priority
  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '1;
    for (int i = 0; i < NLINES; i++) begin
      if (cand[i] && (!found || prio[i] <= best)) begin
        found = 1'b1;
        best  = prio[i];
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/intc_level_banked.sv
module intc_level_banked
  import intc_pkg::*;
#(
  parameter int          NBANKS   = 3,
  parameter logic [7:0]  REVISION = 8'h21
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [32*NBANKS-1:0]   line_i,
  input  logic                   bus_we,
  input  logic [11:0]            bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  output logic                   irq_norm_o,
  output logic                   irq_fast_o
);
  localparam int NLINES = 32 * NBANKS;
  localparam int IDX_W  = $clog2(NLINES);
  localparam int BANK_W = (NBANKS > 1) ? $clog2(NBANKS) : 1;

  // ---------------- address decode ----------------
  logic              word_ok, bank_ok, ilr_ok, ctrl_wr, soft_rst;
  logic [1:0]        bank_no;
  bank_reg_e         bank_sel;
  logic [9:0]        ilr_line;
  logic [BANK_W-1:0] rd_bank, ilr_bank;
  logic [4:0]        ilr_idx;

  assign word_ok  = (bus_addr[1:0] == 2'b00);
  assign bank_no  = bus_addr[6:5];
  assign bank_sel = bank_reg_e'(bus_addr[4:2]);
  assign bank_ok  = word_ok && (bus_addr[11:7] == 5'b00001) && (int'(bank_no) < NBANKS);
  assign ilr_line = bus_addr[11:2] - 10'h040;
  assign ilr_ok   = word_ok && (bus_addr[11:8] != 4'h0) && (int'(ilr_line) < NLINES);
  assign ilr_idx  = ilr_line[4:0];
  assign ilr_bank = ilr_line[5 +: BANK_W];
  assign rd_bank  = bank_no[BANK_W-1:0];
  assign ctrl_wr  = bus_we && word_ok && (bus_addr == A_CTRL);
  assign soft_rst = bus_we && word_ok && (bus_addr == A_CFG) && bus_wdata[1];

  // ---------------- banks ----------------
  logic [31:0]             bk_pend  [NBANKS];
  logic [31:0]             bk_mask  [NBANKS];
  logic [31:0]             bk_route [NBANKS];
  logic [31:0]             bk_raw   [NBANKS];
  logic [31:0][PRIO_W-1:0] bk_prio  [NBANKS];
  logic [NLINES-1:0]             pend_all, mask_all, route_all;
  logic [NLINES-1:0][PRIO_W-1:0] prio_all;

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    intc_bank #(.LINES(32)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .line_i   (line_i[b*32 +: 32]),
      .reg_we   (bus_we && bank_ok && (bank_no == 2'(b))),
      .reg_sel  (bank_sel),
      .wdata    (bus_wdata),
      .ilr_we   (bus_we && ilr_ok && (ilr_line[9:5] == 5'(b))),
      .ilr_idx  (ilr_idx),
      .ilr_wdata(bus_wdata[PRIO_W+1:0]),
      .pend_o   (bk_pend[b]),
      .mask_o   (bk_mask[b]),
      .route_o  (bk_route[b]),
      .prio_o   (bk_prio[b])
    );
    assign bk_raw[b]               = line_i[b*32 +: 32];
    assign pend_all[b*32 +: 32]    = bk_pend[b];
    assign mask_all[b*32 +: 32]    = bk_mask[b];
    assign route_all[b*32 +: 32]   = bk_route[b];
    assign prio_all[b*32 +: 32]    = bk_prio[b];
  end

  // ---------------- per-class arbitration and output ----------------
  logic [NLINES-1:0] cand_c [2];
  logic [1:0]        found_c;
  logic [IDX_W-1:0]  idx_c  [2];
  logic [1:0]        armed_q, armed_n, fire_q, fire_n;
  logic [IDX_W-1:0]  code_q [2];
  logic [IDX_W-1:0]  code_n [2];
  logic              gmask_q, gmask_n;
  logic [1:0]        idle_q, idle_n;

  assign cand_c[0] = pend_all & ~mask_all & ~route_all;
  assign cand_c[1] = pend_all & ~mask_all & route_all;

  for (genvar c = 0; c < 2; c++) begin : g_cls
    intc_arbiter #(.NLINES(NLINES), .IDX_W(IDX_W)) u_arb (
      .cand (cand_c[c]),
      .prio (prio_all),
      .found(found_c[c]),
      .idx  (idx_c[c])
    );

    // R8: an output only rises after an armed cycle with a candidate
    a_r8_fire_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fire_q[c]) |-> $past(found_c[c] && armed_q[c] && !gmask_q));
    // R9: rearm drops the output in the next cycle
    a_r9_rearm_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && bus_wdata[c]) |=> !fire_q[c]);
    // R7: the latched code holds while the class is fired
    a_r7_code_held: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_q[c] && !ctrl_wr && !soft_rst) |=> $stable(code_q[c]));
    // R10: a masked controller never fires an armed class
    a_r10_no_fire_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (gmask_q && armed_q[c]) |=> !fire_q[c]);
  end

  always_comb begin
    armed_n = armed_q;
    fire_n  = fire_q;
    code_n  = code_q;
    gmask_n = ctrl_wr ? bus_wdata[2] : gmask_q;
    idle_n  = (bus_we && word_ok && bus_addr == A_IDLE) ? bus_wdata[1:0] : idle_q;
    for (int c = 0; c < 2; c++) begin
      if (ctrl_wr && bus_wdata[c]) begin
        fire_n[c]  = 1'b0;
        armed_n[c] = 1'b1;
      end else if (armed_q[c] && found_c[c] && !gmask_q) begin
        fire_n[c]  = 1'b1;
        armed_n[c] = 1'b0;
        code_n[c]  = idx_c[c];
      end
    end
    if (soft_rst) begin
      armed_n = 2'b11;
      fire_n  = 2'b00;
      code_n  = '{default: '0};
      gmask_n = 1'b0;
      idle_n  = 2'b00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 2'b11;
      fire_q  <= 2'b00;
      code_q  <= '{default: '0};
      gmask_q <= 1'b0;
      idle_q  <= 2'b00;
    end else begin
      armed_q <= armed_n;
      fire_q  <= fire_n;
      code_q  <= code_n;
      gmask_q <= gmask_n;
      idle_q  <= idle_n;
    end
  end

  assign irq_norm_o = fire_q[0] & ~gmask_q;
  assign irq_fast_o = fire_q[1] & ~gmask_q;

  // ---------------- read mux ----------------
  always_comb begin
    bus_rdata = '0;
    if (bank_ok) begin
      case (bank_sel)
        BR_RAW:  bus_rdata = bk_raw[rd_bank];
        BR_MASK: bus_rdata = bk_mask[rd_bank];
        BR_PNRM: bus_rdata = bk_pend[rd_bank] & ~bk_mask[rd_bank] & ~bk_route[rd_bank];
        BR_PFST: bus_rdata = bk_pend[rd_bank] & ~bk_mask[rd_bank] & bk_route[rd_bank];
        default: bus_rdata = '0;
      endcase
    end else if (ilr_ok) begin
      bus_rdata = {24'h0, bk_prio[ilr_bank][ilr_idx], 1'b0, bk_route[ilr_bank][ilr_idx]};
    end else if (word_ok) begin
      case (bus_addr)
        A_REV:   bus_rdata = {24'h0, REVISION};
        A_STAT:  bus_rdata = 32'h1;
        A_CODEN: bus_rdata = 32'(code_q[0]);
        A_CODEF: bus_rdata = 32'(code_q[1]);
        A_CTRL:  bus_rdata = {29'h0, gmask_q, 2'b00};
        A_IDLE:  bus_rdata = {30'h0, idle_q};
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: tb/tb_intc_level_banked.sv
module tb_intc_level_banked;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 3;
  localparam int NL = 32 * NB;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [NL-1:0] lines;
  logic        we;
  logic [11:0] addr;
  logic [31:0] wd;
  logic [31:0] rdata;
  logic        irq_n, irq_f;

  int errors = 0;
  int checks = 0;
  bit running = 0;

  intc_level_banked #(.NBANKS(NB), .REVISION(8'h21)) dut (
    .clk(clk), .rst_n(rst_n), .line_i(lines), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wd), .bus_rdata(rdata), .irq_norm_o(irq_n), .irq_fast_o(irq_f)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference ----------------
  logic [31:0] mpend [NB];
  logic [31:0] mswi  [NB];
  logic [31:0] mmask [NB];
  logic [31:0] minq  [NB];
  int  mprio  [NL];
  bit  mroute [NL];
  bit  marmed [2];
  bit  mfire  [2];
  int  mcode  [2];
  bit  mgmask;
  int  midle;

  task automatic mreset();
    for (int b = 0; b < NB; b++) begin
      mpend[b] = 0; mswi[b] = 0; mmask[b] = 32'hFFFF_FFFF; minq[b] = 0;
    end
    for (int n = 0; n < NL; n++) begin mprio[n] = 0; mroute[n] = 0; end
    for (int c = 0; c < 2; c++) begin marmed[c] = 1; mfire[c] = 0; mcode[c] = 0; end
    mgmask = 0; midle = 0;
  endtask

  function automatic bit mcand(int c, int n);
    return mpend[n/32][n%32] && !mmask[n/32][n%32] && (int'(mroute[n]) == c);
  endfunction

  // most urgent priority first, then highest line number
  task automatic marb(input int c, output bit f, output int idx);
    f = 0; idx = 0;
    for (int p = 0; p < 64 && !f; p++)
      for (int n = NL-1; n >= 0 && !f; n--)
        if (mcand(c, n) && mprio[n] == p) begin f = 1; idx = n; end
  endtask

  task automatic mstep();
    bit f[2];
    int ix[2];
    int a;
    a = int'(addr);
    for (int c = 0; c < 2; c++) marb(c, f[c], ix[c]);
    for (int b = 0; b < NB; b++) begin
      logic [31:0] in, fl, p, s, m;
      in = lines[b*32 +: 32];
      fl = minq[b] & ~in;
      p  = (mpend[b] & ~fl) | (mswi[b] & fl);
      s  = mswi[b]; m = mmask[b];
      if (we && a >= 'h80 + 32*b && a < 'h80 + 32*(b+1)) begin
        case ((a >> 2) & 7)
          1: m = wd;
          2: m = m & ~wd;
          3: m = m | wd;
          4: begin s = s | wd; p = p | wd; end
          5: begin s = s & ~wd; p = s & in; end
          default: ;
        endcase
      end
      mpend[b] = p | in; mswi[b] = s; mmask[b] = m; minq[b] = in;
    end
    if (we && a >= 'h100 && ((a - 'h100) >> 2) < NL) begin
      mprio[(a - 'h100) >> 2]  = (wd >> 2) & 63;
      mroute[(a - 'h100) >> 2] = wd[0];
    end
    for (int c = 0; c < 2; c++) begin
      if (we && a == 'h48 && wd[c]) begin mfire[c] = 0; marmed[c] = 1; end
      else if (marmed[c] && f[c] && !mgmask) begin mfire[c] = 1; marmed[c] = 0; mcode[c] = ix[c]; end
    end
    if (we && a == 'h48) mgmask = wd[2];
    if (we && a == 'h50) midle = wd & 3;
    if (we && a == 'h10 && wd[1]) mreset();
  endtask

  function automatic logic [31:0] mread(int a);
    if (a >= 'h80 && a < 'h80 + 32*NB) begin
      int b = (a - 'h80) >> 5;
      logic [31:0] rt = '0;
      for (int i = 0; i < 32; i++) rt[i] = mroute[32*b + i];
      case ((a >> 2) & 7)
        0: return lines[b*32 +: 32];
        1: return mmask[b];
        6: return mpend[b] & ~mmask[b] & ~rt;
        7: return mpend[b] & ~mmask[b] & rt;
        default: return 0;
      endcase
    end
    if (a >= 'h100 && ((a - 'h100) >> 2) < NL)
      return 32'((mprio[(a - 'h100) >> 2] << 2) | int'(mroute[(a - 'h100) >> 2]));
    case (a)
      'h00: return 32'h21;
      'h14: return 1;
      'h40: return 32'(mcode[0]);
      'h44: return 32'(mcode[1]);
      'h48: return mgmask ? 32'h4 : 32'h0;
      'h50: return 32'(midle);
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) mreset();
    else mstep();
  end

  // ---------------- checking ----------------
  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (running && rst_n) begin
      chk("R8 normal output", 32'(irq_n), 32'(mfire[0] && !mgmask));
      chk("R10 fast output", 32'(irq_f), 32'(mfire[1] && !mgmask));
    end
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); we = 1; addr = 12'(a); wd = d;
    @(negedge clk); we = 0; wd = '0;
  endtask

  task automatic rd(string tag, int a);
    @(negedge clk); addr = 12'(a); #1;
    chk(tag, rdata, mread(a));
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setline(int n, bit v);
    @(negedge clk); lines[n] = v;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0; lines = '0; we = 0; addr = '0; wd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1; running = 1;

    // R1 reset state
    rd("R1 mask bank0", 'h84);
    rd("R1 mask bank2", 'hC4);
    rd("R1 normal code", 'h40);
    rd("R1 fast code", 'h44);
    rd("R1 level reg", 'h104);
    chk("R1 mask value", rdata, mread('h104));
    rd("R11 status", 'h14);
    chk("R11 status is one", rdata, 32'h1);
    rd("R12 revision", 'h00);

    // R3 level pending, R2 mask clear, R8 fire, R7 code
    setline(5, 1); idle(1);
    rd("R3 raw inputs", 'h80);
    rd("R5 masked view", 'h98);
    wr('h88, 32'h20);
    rd("R2 mask after clear", 'h84);
    idle(2);
    rd("R5 normal view", 'h98);
    rd("R7 single code", 'h40);

    // R6 level regs, R7 priority across banks and tie break, R9 rearm
    wr('h114, 10 << 2);
    wr('h1A0, 3 << 2);
    wr('h1A4, 3 << 2);
    rd("R6 level readback", 'h114);
    setline(40, 1); setline(41, 1);
    wr('hA8, 32'h300);
    wr('h48, 32'h1);
    idle(3);
    rd("R7 tie to higher line", 'h40);
    wr('h1A4, 9 << 2);
    wr('h48, 32'h1);
    idle(3);
    rd("R7 lower value wins", 'h40);

    // R4 software set, fast class
    wr('h218, 32'h1);
    wr('hD0, 32'h40);
    wr('hC8, 32'h40);
    idle(2);
    rd("R5 fast view", 'hDC);
    rd("R7 fast code", 'h44);
    wr('hD0, 32'h80);
    wr('hC8, 32'h80);
    rd("R4 soft pending normal", 'hD8);
    wr('hD4, 32'h40);
    rd("R4 clear drops soft-only bits", 'hD8);
    rd("R4 clear fast view", 'hDC);

    // R3 fall with software bit present and absent
    wr('h90, 32'h20);
    setline(5, 0); idle(1);
    rd("R3 fall keeps soft bit", 'h98);
    setline(40, 0); idle(1);
    rd("R3 fall without soft bit", 'hB8);

    // R10 global mask
    wr('h48, 32'h4);
    rd("R10 gmask readback", 'h48);
    wr('h48, 32'h7);
    idle(3);
    wr('h48, 32'h0);
    idle(3);

    // R2 mask set and read of set/clear
    wr('h8C, 32'h20);
    rd("R2 mask after set", 'h84);
    rd("R2 view after set", 'h98);
    rd("R2 set reg reads zero", 'h8C);
    rd("R2 clear reg reads zero", 'h88);

    // R12 read-only writes and idle bits
    wr('h00, 32'hFF); wr('h14, 32'h0); wr('h40, 32'h1F); wr('h80, 32'hFFFF_FFFF);
    wr('h98, 32'hFFFF_FFFF);
    rd("R12 revision unchanged", 'h00);
    rd("R12 code unchanged", 'h40);
    rd("R12 view unchanged", 'hB8);
    wr('h50, 32'hFFFF_FFFE);
    rd("R12 idle bits", 'h50);
    wr('h120, 32'hFF);
    rd("R6 bit1 reads zero", 'h120);
    rd("R6 beyond last line", 'h280);
    rd("R2 missing bank", 'hE4);

    // R11 soft reset
    setline(41, 1);
    wr('h10, 32'h2);
    rd("R11 mask restored", 'hA4);
    rd("R11 level cleared", 'h1A4);
    rd("R11 code cleared", 'h40);
    rd("R11 idle cleared", 'h50);
    idle(3);

    running = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule